// File: doc/BRIEF.md
# Event Handshake Accelerator Sequencer

This block sits in the programmable fabric beside a multi-core processor cluster. It lets the cores start an accelerator job and be woken when the job ends, with no interrupt involved. A core signals "start" by flipping the level of a single event wire. The block treats any change of that level as a start request. It then sets up the job from its configuration inputs:

- a source base address,
- a word count,
- a result base address.

The block reads the input words over a request/ready/valid memory port and hands each one to an external processing datapath. It waits for the datapath to finish, then writes the results back over a request/ready memory port. When the last write has been accepted, it flips its own event output so that any core sleeping in wait-for-event standby wakes up.

The block samples the per-core wait-for-event standby bits at the moment of completion. It records which cores were asleep, and keeps a sticky flag set when no core was asleep at that moment. The wait-for-interrupt standby bits are only passed on as a registered copy. A start request that arrives while a job is running is held in a single pending slot. Any further request during the same job is dropped and raises a sticky overflow flag.

Top module: `evt_accel_seq`

## Requirements
- R1: A change of level on `sev_tgl_i` in either direction, rising or falling, starts exactly one job when the block is idle.
- R2: The source address, word count and result address are captured when a job starts. Later changes on the configuration inputs have no effect on the addresses of that job.
- R3: A job with count field C fetches N = C+1 words from source+0 up to source+N-1, in ascending order, modulo 2^AW. Only one read is outstanding at a time. Each returned word is presented on `dp_in_*` with its index 0..N-1.
- R4: After the fetch, the block waits in the processing state until `dp_done_i` is high. It issues no write in that state.
- R5: Write-back stores word i at result+i (modulo 2^AW), for i = 0..N-1 in ascending order. The write data is `dp_res_data_i` for `dp_res_idx_o` = i. A request that is not accepted keeps its address until `wr_ready_i` is high.
- R6: `evt_in_o` inverts exactly once per job and then holds its level. It changes at the clock edge that follows acceptance of the job's last write, never earlier. It resets to 0.
- R7: `state_o` encodes idle=0, fetch=1, process=2, writeback=3, signal=4. The signal state lasts exactly one cycle and is entered together with the `evt_in_o` change.
- R8: One start request that arrives while a job is busy (states 1 to 4) is kept and served after that job ends. This holds even when the request arrives in the signal cycle. Without a further request, the block then goes idle.
- R9: Each further start request during the same busy period is dropped and sets the sticky `ovf_o`.
- R10: At each `evt_in_o` change, `wake_mask_o` takes the value of `wfe_stby_i`. If `wfe_stby_i` is all zero at that moment, the sticky `stby_miss_o` is set.
- R11: `wfi_stby_o` equals `wfi_stby_i` delayed by one clock. The wait-for-interrupt bits have no effect on the job sequence.
- R12: After reset: `state_o`=0, `evt_in_o`=0, `ovf_o`=0, `stby_miss_o`=0, `wake_mask_o`=0, no read request and no write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sev_tgl_i | input | 1 | Asynchronous start toggle from the cores |
| wfe_stby_i | input | NCPU | Per-core wait-for-event standby level |
| wfi_stby_i | input | NCPU | Per-core wait-for-interrupt standby level |
| cfg_src_i | input | AW | Source base address |
| cfg_cnt_i | input | CW | Word count minus one |
| cfg_dst_i | input | AW | Result base address |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ready_i | input | 1 | Read request accepted |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data |
| dp_in_valid_o | output | 1 | Input word valid to the datapath |
| dp_in_idx_o | output | CW | Index of the input word |
| dp_in_data_o | output | DW | Input word |
| dp_done_i | input | 1 | Datapath finished processing |
| dp_res_idx_o | output | CW | Index of the result word requested |
| dp_res_data_i | input | DW | Result word for `dp_res_idx_o` |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| wr_ready_i | input | 1 | Write request accepted |
| evt_in_o | output | 1 | Completion toggle to the cores |
| state_o | output | 3 | Sequencer state code |
| wake_mask_o | output | NCPU | Standby bits captured at completion |
| stby_miss_o | output | 1 | Sticky: a completion occurred with no core in standby |
| ovf_o | output | 1 | Sticky: a start request was dropped |
| wfi_stby_o | output | NCPU | Registered copy of `wfi_stby_i` |

## Verification
The start detector and the completion signalling can act in the same cycle. A fresh start request may be detected in the single signal cycle while `evt_in_o` is flipping. The bench provokes this by starting a short job and, on each pass, re-toggling the start wire a different number of cycles after write-back begins. Together the passes sweep the request across the write-back tail, the signal cycle and the idle cycles that follow. Every pass is judged by counting completion toggles: exactly two must appear, `ovf_o` must stay low and the block must settle idle.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_FETCH = 3'd1,
    ST_PROC = 3'd2,
    ST_WB = 3'd3,
    ST_SIG = 3'd4
  } seq_state_e;

  // Word address: base plus index, wrapping at the caller's width (AW <= 32).
  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + idx;
  endfunction

  // A level change between two samples marks one event.
  function automatic logic level_changed(input logic cur, input logic prev);
    return cur ^ prev;
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge import evt_seq_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic evt_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // R1: both directions count
  assign evt_o = level_changed(sync_q, prev_q);

endmodule

// File: rtl/evt_start_queue.sv
module evt_start_queue (
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt_i,
  input  logic busy_i,
  output logic go_o,
  output logic ovf_o
);
  logic pend_q, ovf_q;

  assign go_o  = !busy_i && (pend_q || start_evt_i);
  assign ovf_o = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (busy_i) begin
      if (start_evt_i) begin
        if (pend_q) ovf_q <= 1'b1;   // R9
        else        pend_q <= 1'b1;  // R8
      end
    end else begin
      // idle: the slot is consumed; a coincident fresh request refills it
      pend_q <= pend_q && start_evt_i;
    end
  end

  p_pend_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && start_evt_i && !pend_q |=> pend_q);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && start_evt_i && pend_q |=> ovf_q);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/evt_job_fsm.sv
module evt_job_fsm import evt_seq_pkg::*; #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 4,
  parameter int NCPU = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [AW-1:0]   cfg_src_i,
  input  logic [CW-1:0]   cfg_cnt_i,
  input  logic [AW-1:0]   cfg_dst_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_ready_i,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            dp_in_valid_o,
  output logic [CW-1:0]   dp_in_idx_o,
  output logic [DW-1:0]   dp_in_data_o,
  input  logic            dp_done_i,
  output logic [CW-1:0]   dp_res_idx_o,
  input  logic [DW-1:0]   dp_res_data_i,
  output logic            wr_req_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  input  logic            wr_ready_i,
  input  logic [NCPU-1:0] wfe_stby_i,
  output logic [2:0]      state_o,
  output logic            evt_in_o,
  output logic [NCPU-1:0] wake_mask_o,
  output logic            stby_miss_o
);
  seq_state_e st_q, st_d;
  logic [AW-1:0]   src_q, dst_q;
  logic [CW-1:0]   last_q, idx_q;
  logic            rd_wait_q, evt_q, miss_q;
  logic [NCPU-1:0] wake_q;

  // named internal events
  logic at_last, rd_fire, rd_ret, wr_fire, sig_enter, job_start;
  assign at_last   = (idx_q == last_q);
  assign job_start = (st_q == ST_IDLE) && go_i;
  assign rd_fire   = rd_req_o && rd_ready_i;
  assign rd_ret    = (st_q == ST_FETCH) && rd_wait_q && rd_valid_i;
  assign wr_fire   = wr_req_o && wr_ready_i;
  assign sig_enter = wr_fire && at_last;

  assign rd_req_o      = (st_q == ST_FETCH) && !rd_wait_q;
  assign rd_addr_o     = AW'(word_addr(32'(src_q), 32'(idx_q)));
  assign dp_in_valid_o = rd_ret;
  assign dp_in_idx_o   = idx_q;
  assign dp_in_data_o  = rd_data_i;
  assign wr_req_o      = (st_q == ST_WB);
  assign wr_addr_o     = AW'(word_addr(32'(dst_q), 32'(idx_q)));
  assign dp_res_idx_o  = idx_q;
  assign wr_data_o     = dp_res_data_i;
  assign state_o       = st_q;
  assign evt_in_o      = evt_q;
  assign wake_mask_o   = wake_q;
  assign stby_miss_o   = miss_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (go_i) st_d = ST_FETCH;
      ST_FETCH: if (rd_ret && at_last) st_d = ST_PROC;
      ST_PROC:  if (dp_done_i) st_d = ST_WB;
      ST_WB:    if (sig_enter) st_d = ST_SIG;
      ST_SIG:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      src_q     <= '0;
      dst_q     <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      rd_wait_q <= 1'b0;
      evt_q     <= 1'b0;
      miss_q    <= 1'b0;
      wake_q    <= '0;
    end else begin
      st_q <= st_d;
      if (job_start) begin            // R2: capture configuration once
        src_q     <= cfg_src_i;
        dst_q     <= cfg_dst_i;
        last_q    <= cfg_cnt_i;
        idx_q     <= '0;
        rd_wait_q <= 1'b0;
      end
      if (rd_fire) rd_wait_q <= 1'b1;
      if (rd_ret) begin
        rd_wait_q <= 1'b0;
        idx_q     <= at_last ? '0 : idx_q + 1'b1;
      end
      if (wr_fire) idx_q <= at_last ? '0 : idx_q + 1'b1;
      if (sig_enter) begin            // R6, R10
        evt_q  <= ~evt_q;
        wake_q <= wfe_stby_i;
        if (wfe_stby_i == '0) miss_q <= 1'b1;
      end
    end
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) && ($past(st_q) != ST_IDLE) |->
      $stable(src_q) && $stable(dst_q) && $stable(last_q));
  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_req_o);
  p_no_write_proc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PROC) |-> !wr_req_o);
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o && !wr_ready_i |=> wr_req_o && $stable(wr_addr_o));
  p_toggle_in_sig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != $past(evt_q)) |-> (st_q == ST_SIG));
  p_sig_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SIG) |=> (st_q == ST_IDLE));
  p_miss_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q |=> miss_q);

endmodule

// File: rtl/evt_accel_seq.sv
module evt_accel_seq import evt_seq_pkg::*; #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int CW   = 4,
  parameter int NCPU = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sev_tgl_i,
  input  logic [NCPU-1:0] wfe_stby_i,
  input  logic [NCPU-1:0] wfi_stby_i,
  input  logic [AW-1:0]   cfg_src_i,
  input  logic [CW-1:0]   cfg_cnt_i,
  input  logic [AW-1:0]   cfg_dst_i,
  output logic            rd_req_o,
  output logic [AW-1:0]   rd_addr_o,
  input  logic            rd_ready_i,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            dp_in_valid_o,
  output logic [CW-1:0]   dp_in_idx_o,
  output logic [DW-1:0]   dp_in_data_o,
  input  logic            dp_done_i,
  output logic [CW-1:0]   dp_res_idx_o,
  input  logic [DW-1:0]   dp_res_data_i,
  output logic            wr_req_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  input  logic            wr_ready_i,
  output logic            evt_in_o,
  output logic [2:0]      state_o,
  output logic [NCPU-1:0] wake_mask_o,
  output logic            stby_miss_o,
  output logic            ovf_o,
  output logic [NCPU-1:0] wfi_stby_o
);
  logic start_evt, go, busy;
  logic [NCPU-1:0] wfi_q;

  assign busy       = (state_o != ST_IDLE);
  assign wfi_stby_o = wfi_q;

  evt_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sev_tgl_i), .evt_o(start_evt)
  );

  evt_start_queue u_queue (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .busy_i(busy),
    .go_o(go), .ovf_o(ovf_o)
  );

  evt_job_fsm #(.AW(AW), .DW(DW), .CW(CW), .NCPU(NCPU)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go),
    .cfg_src_i(cfg_src_i), .cfg_cnt_i(cfg_cnt_i), .cfg_dst_i(cfg_dst_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ready_i(rd_ready_i),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .dp_in_valid_o(dp_in_valid_o), .dp_in_idx_o(dp_in_idx_o), .dp_in_data_o(dp_in_data_o),
    .dp_done_i(dp_done_i), .dp_res_idx_o(dp_res_idx_o), .dp_res_data_i(dp_res_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_ready_i(wr_ready_i),
    .wfe_stby_i(wfe_stby_i), .state_o(state_o), .evt_in_o(evt_in_o),
    .wake_mask_o(wake_mask_o), .stby_miss_o(stby_miss_o)
  );

  // R11: report-only copy of the wait-for-interrupt levels
  always_ff @(posedge clk) begin
    if (!rst_n) wfi_q <= '0;
    else        wfi_q <= wfi_stby_i;
  end

  p_go_only_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (state_o == ST_FETCH));

endmodule

// File: tb/evt_accel_seq_test.sv
module evt_accel_seq_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sev_tgl_i = 1'b0;
  logic [1:0] wfe_stby_i = 2'b11;
  logic [1:0] wfi_stby_i = 2'b00;
  logic [15:0] cfg_src_i = '0, cfg_dst_i = '0;
  logic [3:0]  cfg_cnt_i = '0;
  logic rd_req_o, rd_ready_i = 1'b0, rd_valid_i = 1'b0;
  logic [15:0] rd_addr_o, rd_data_i = '0;
  logic dp_in_valid_o, dp_done_i = 1'b0;
  logic [3:0] dp_in_idx_o, dp_res_idx_o;
  logic [15:0] dp_in_data_o, dp_res_data_i;
  logic wr_req_o, wr_ready_i = 1'b0;
  logic [15:0] wr_addr_o, wr_data_o;
  logic evt_in_o, stby_miss_o, ovf_o;
  logic [2:0] state_o;
  logic [1:0] wake_mask_o, wfi_stby_o;

  always #2.5 clk = ~clk;   // 200 MHz

  evt_accel_seq uut (
    .clk(clk), .rst_n(rst_n), .sev_tgl_i(sev_tgl_i), .wfe_stby_i(wfe_stby_i),
    .wfi_stby_i(wfi_stby_i), .cfg_src_i(cfg_src_i), .cfg_cnt_i(cfg_cnt_i),
    .cfg_dst_i(cfg_dst_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ready_i(rd_ready_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .dp_in_valid_o(dp_in_valid_o), .dp_in_idx_o(dp_in_idx_o), .dp_in_data_o(dp_in_data_o),
    .dp_done_i(dp_done_i), .dp_res_idx_o(dp_res_idx_o), .dp_res_data_i(dp_res_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .wr_ready_i(wr_ready_i), .evt_in_o(evt_in_o), .state_o(state_o),
    .wake_mask_o(wake_mask_o), .stby_miss_o(stby_miss_o), .ovf_o(ovf_o),
    .wfi_stby_o(wfi_stby_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // expected job and bench-side models
  logic [15:0] exp_src = '0, exp_dst = '0;
  int exp_n = 1, dly = 1;
  int rd_k = 0, wr_k = 0, din_k = 0, pc = 0, jobs = 0, cyc = 0, mem_cnt = 0;
  bit mem_busy = 0, rd_fire_seen = 0, sig_seen = 0;
  logic [15:0] mem_addr = '0, rd_addr_seen = '0;
  logic evt_seen = 1'b0;
  logic [15:0] din [16];

  assign dp_res_data_i = din[dp_res_idx_o] ^ 16'hA5A5;

  function automatic logic [15:0] fmem(input logic [15:0] a);
    return a * 16'd3 + 16'h0101;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: sample at negedge, drive inputs just after posedge
  initial begin
    for (int i = 0; i < 16; i++) din[i] = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      rd_fire_seen = rd_req_o && rd_ready_i;
      if (rd_req_o && (mem_busy || rd_valid_i))
        chk(0, "R3 second read while one outstanding", 32'(rd_addr_o), 32'(mem_addr));
      if (rd_fire_seen) begin
        chk(rd_addr_o == exp_src + 16'(rd_k), "R3 read address", 32'(rd_addr_o), 32'(exp_src + 16'(rd_k)));
        rd_addr_seen = rd_addr_o;
        rd_k++;
      end
      if (rd_valid_i) begin
        chk(dp_in_valid_o && dp_in_idx_o == 4'(din_k) && dp_in_data_o == fmem(exp_src + 16'(din_k)),
            "R3 datapath word", {dp_in_valid_o, 11'd0, dp_in_idx_o, dp_in_data_o},
            {1'b1, 11'd0, 4'(din_k), fmem(exp_src + 16'(din_k))});
        din[din_k[3:0]] = dp_in_data_o;
        din_k++;
      end
      if (state_o == 3'd2) begin
        pc++;
        if (wr_req_o) chk(0, "R4 write during processing", 32'(wr_addr_o), 32'd0);
      end
      if (state_o == 3'd3 && pc != 0) begin
        chk(pc == dly, "R4 processing wait length", 32'(pc), 32'(dly));
        pc = 0;
      end
      if (wr_req_o && wr_ready_i) begin
        chk(wr_addr_o == exp_dst + 16'(wr_k), "R5 write address", 32'(wr_addr_o), 32'(exp_dst + 16'(wr_k)));
        chk(wr_data_o == (fmem(exp_src + 16'(wr_k)) ^ 16'hA5A5), "R5 write data",
            32'(wr_data_o), 32'(fmem(exp_src + 16'(wr_k)) ^ 16'hA5A5));
        wr_k++;
      end
      if (sig_seen) begin
        chk(state_o != 3'd4, "R7 signal state longer than one cycle", 32'(state_o), 32'd0);
        sig_seen = 0;
      end
      if (evt_in_o != evt_seen) begin
        chk(state_o == 3'd4, "R7 toggle with signal state", 32'(state_o), 32'd4);
        chk(wr_k == exp_n && rd_k == exp_n, "R6 toggle after all writes", 32'(wr_k), 32'(exp_n));
        chk(wake_mask_o == wfe_stby_i, "R10 wake mask", 32'(wake_mask_o), 32'(wfe_stby_i));
        evt_seen = evt_in_o;
        jobs++;
        rd_k = 0; wr_k = 0; din_k = 0;
        sig_seen = 1;
      end
      @(posedge clk);
      #1;
      cyc++;
      rd_valid_i = 1'b0;
      if (mem_busy) begin
        mem_cnt--;
        if (mem_cnt == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = fmem(mem_addr);
          mem_busy   = 0;
        end
      end
      if (rd_fire_seen) begin
        mem_busy = 1;
        mem_cnt  = 1 + cyc % 2;
        mem_addr = rd_addr_seen;
      end
      rd_ready_i = (cyc % 3) != 0;
      wr_ready_i = (cyc % 4) != 1;
      dp_done_i  = (state_o == 3'd2) && (pc + 1 == dly);
    end
  end

  task automatic wait_jobs(input int target);
    for (int t = 0; t < 3000 && jobs < target; t++) @(negedge clk);
  endtask

  task automatic wait_busy();
    for (int t = 0; t < 30 && state_o == 3'd0; t++) @(negedge clk);
  endtask

  task automatic flip_sev();
    @(posedge clk);
    #1;
    sev_tgl_i = ~sev_tgl_i;
  endtask

  task automatic set_job(input logic [15:0] src, input logic [3:0] cnt, input logic [15:0] dst, input int d);
    @(posedge clk);
    #1;
    cfg_src_i = src; cfg_cnt_i = cnt; cfg_dst_i = dst;
    exp_src = src; exp_dst = dst; exp_n = int'(cnt) + 1; dly = d;
  endtask

  task automatic run_job(input logic [15:0] src, input logic [3:0] cnt, input logic [15:0] dst,
                         input int d, input bit scramble);
    int j0;
    logic lvl;
    set_job(src, cnt, dst, d);
    j0 = jobs;
    lvl = ~sev_tgl_i;
    flip_sev();
    if (scramble) begin   // R2: change configuration mid-job
      wait_busy();
      cfg_src_i = ~src; cfg_cnt_i = ~cnt; cfg_dst_i = src ^ dst ^ 16'h1234;
    end
    wait_jobs(j0 + 1);
    chk(jobs == j0 + 1, lvl ? "R1 rising toggle runs one job" : "R1 falling toggle runs one job",
        32'(jobs - j0), 32'd1);
    repeat (6) @(negedge clk);
    chk(jobs == j0 + 1 && state_o == 3'd0, "R1 no extra job", 32'(jobs - j0), 32'd1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(state_o == 3'd0 && evt_in_o == 1'b0 && ovf_o == 1'b0 && stby_miss_o == 1'b0 &&
        wake_mask_o == 2'b00 && !rd_req_o && !wr_req_o, "R12 reset state",
        {state_o, evt_in_o, ovf_o, stby_miss_o, rd_req_o, wr_req_o}, 32'd0);

    // R11: one-cycle registered copy
    @(posedge clk); #1 wfi_stby_i = 2'b10;
    @(negedge clk);
    chk(wfi_stby_o == 2'b00, "R11 wfi copy before capture", 32'(wfi_stby_o), 32'd0);
    @(negedge clk);
    chk(wfi_stby_o == 2'b10, "R11 wfi copy after one clock", 32'(wfi_stby_o), 32'd2);

    // count sweep, both toggle directions, R2 scrambling on odd counts, R11 values varying
    for (int c = 0; c < 8; c++) begin
      wfi_stby_i = 2'(c);
      run_job(16'h0100 + 16'(c * 16), 4'(c), 16'h8000 + 16'(c * 32), c % 4 + 1, c[0]);
    end
    run_job(16'hFFFD, 4'd5, 16'hFFFE, 2, 1'b0);   // R3/R5 address wrap
    run_job(16'h2000, 4'd15, 16'h3000, 4, 1'b1);  // maximum count
    chk(stby_miss_o == 1'b0 && ovf_o == 1'b0, "R10 no miss with cores asleep", {stby_miss_o, ovf_o}, 32'd0);

    // R10: partial standby, then none
    wfe_stby_i = 2'b01;
    run_job(16'h0400, 4'd2, 16'h0500, 1, 1'b0);
    chk(wake_mask_o == 2'b01 && stby_miss_o == 1'b0, "R10 partial mask", {wake_mask_o, stby_miss_o}, 32'd2);
    wfe_stby_i = 2'b00;
    run_job(16'h0600, 4'd1, 16'h0700, 1, 1'b0);
    chk(stby_miss_o == 1'b1, "R10 miss set with no core asleep", 32'(stby_miss_o), 32'd1);
    wfe_stby_i = 2'b11;
    run_job(16'h0800, 4'd1, 16'h0900, 1, 1'b0);
    chk(stby_miss_o == 1'b1 && wake_mask_o == 2'b11, "R10 miss sticky", {wake_mask_o, stby_miss_o}, 32'd7);

    // R8: one request during busy is served later
    begin
      int j0;
      set_job(16'h1000, 4'd7, 16'h1100, 2);
      j0 = jobs;
      flip_sev();
      wait_busy();
      repeat (4) @(negedge clk);
      flip_sev();
      wait_jobs(j0 + 2);
      repeat (40) @(negedge clk);
      chk(jobs == j0 + 2 && ovf_o == 1'b0 && state_o == 3'd0, "R8 pending request served once",
          32'(jobs - j0), 32'd2);
    end

    // R8: request swept across write-back tail, signal cycle and idle
    for (int off = 0; off < 10; off++) begin
      int j0;
      set_job(16'h1200 + 16'(off), 4'd1, 16'h1300, 1);
      j0 = jobs;
      flip_sev();
      for (int t = 0; t < 200 && state_o != 3'd3; t++) @(negedge clk);
      repeat (off) @(negedge clk);
      flip_sev();
      wait_jobs(j0 + 2);
      repeat (20) @(negedge clk);
      chk(jobs == j0 + 2 && ovf_o == 1'b0 && state_o == 3'd0, "R8 request near completion",
          32'(jobs - j0), 32'd2);
    end

    // R9: further requests during busy are dropped
    begin
      int j0;
      set_job(16'h1400, 4'd7, 16'h1500, 3);
      j0 = jobs;
      flip_sev();
      wait_busy();
      for (int k = 0; k < 3; k++) begin
        repeat (5) @(negedge clk);
        flip_sev();
      end
      wait_jobs(j0 + 2);
      repeat (60) @(negedge clk);
      chk(jobs == j0 + 2, "R9 extra requests dropped", 32'(jobs - j0), 32'd2);
      chk(ovf_o == 1'b1, "R9 overflow flag set", 32'(ovf_o), 32'd1);
    end
    run_job(16'h1600, 4'd0, 16'h1700, 1, 1'b0);
    chk(ovf_o == 1'b1, "R9 overflow flag sticky", 32'(ovf_o), 32'd1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired state=%0d", state_o);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule